// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block is the multiply-accumulate engine of a 32-bit processor datapath. It keeps a 64-bit running total as two 32-bit words, high above low. Each valid command either adds a signed product to the total, subtracts one from it, or reads the total out and clears it. The product is always cut down to 32 bits and then sign-extended to 64 bits before it meets the accumulator. This differs from a full-width multiply-accumulate and matters whenever the true product does not fit in 32 bits.

The pipeline around the block fetches the operands and places them on the command inputs with a one-cycle valid strobe. A read-and-clear command returns only the low accumulator word. That word appears on the read output one cycle later and stays there until the next read. The full 64-bit accumulator value is driven on a separate output so the high word can be seen.

Top module: `mac_accum`

## Requirements
- R1: While synchronous reset is high at a clock edge, the accumulator and the read output both become zero.
- R2: Command code 0 (multiply-add) adds P to the 64-bit accumulator at the next edge. P is the low 32 bits of `op_a * op_b`, sign-extended from bit 31.
- R3: Command code 1 (multiply-subtract) subtracts the same sign-extended 32-bit product P from the accumulator at the next edge.
- R4: Command code 2 (immediate multiply-add) adds the sign-extended low 32 bits of `op_a` times the immediate. The immediate is first sign-extended from bit 15 to 32 bits, and `op_b` is ignored.
- R5: Command code 3 (read-and-clear) loads the read output with accumulator bits 31:0 and sets all 64 accumulator bits to zero at the same edge. The read output keeps its value through every other cycle.
- R6: A read-and-clear issued in the cycle right after an accumulate returns the low word that includes that accumulate.
- R7: Accumulator arithmetic wraps modulo 2^64 in both directions and raises no flag. Subtracting 1 from zero gives all ones, and adding 1 to all ones gives zero.
- R8: With `cmd_valid` low, the accumulator and the read output keep their values, whatever the other inputs hold.
- R9: Product bits above bit 31 are dropped. For example, 0x00010000 times 0x00010000 adds nothing, and 0x00008000 times 0x00010000 adds 0xFFFFFFFF80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe for this cycle |
| cmd_op | input | 2 | 0 multiply-add, 1 multiply-subtract, 2 immediate multiply-add, 3 read-and-clear |
| op_a | input | 32 | First register operand |
| op_b | input | 32 | Second register operand |
| imm | input | 16 | Signed immediate for command 2 |
| rd_data | output | 32 | Low accumulator word captured by the last read-and-clear |
| acc_out | output | 64 | Current accumulator, high word in bits 63:32 |

## Verification
Each command's result is due one edge after the command is accepted. The accumulator result appears on `acc_out` and the read result on `rd_data`. The bench drives each command on a falling edge and compares both outputs at the following falling edge, after exactly one rising edge, against a reference model updated in step with the command. Back-to-back accumulate-then-read pairs are driven in adjacent cycles, so the read must reflect an accumulate that completed only one edge before. Idle cycles are checked the same way to confirm that both outputs are stable.

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [IW-1:0]  imm,
  output logic [W-1:0]   rd_data,
  output logic [2*W-1:0] acc_out
);
  localparam int AW = 2 * W;
  localparam logic [1:0] OP_MADD = 2'd0;
  localparam logic [1:0] OP_MSUB = 2'd1;
  localparam logic [1:0] OP_IMAD = 2'd2;
  localparam logic [1:0] OP_RDCL = 2'd3;

  logic [W-1:0]  acc_hi, acc_lo;
  logic [W-1:0]  mul_b, prod_w;
  logic [AW-1:0] acc_cur, prod_x, acc_nxt;

  assign mul_b   = (cmd_op == OP_IMAD) ? {{(W-IW){imm[IW-1]}}, imm} : op_b;
  assign prod_w  = op_a * mul_b;
  assign prod_x  = {{W{prod_w[W-1]}}, prod_w};
  assign acc_cur = {acc_hi, acc_lo};

  always_comb begin
    unique case (cmd_op)
      OP_MADD, OP_IMAD: acc_nxt = acc_cur + prod_x;
      OP_MSUB:          acc_nxt = acc_cur - prod_x;
      default:          acc_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_hi  <= '0;
      acc_lo  <= '0;
      rd_data <= '0;
    end else if (cmd_valid) begin
      acc_hi <= acc_nxt[AW-1:W];
      acc_lo <= acc_nxt[W-1:0];
      if (cmd_op == OP_RDCL) rd_data <= acc_lo;
    end
  end

  assign acc_out = acc_cur;
endmodule

// File: rtl/mac_accum_chk.sv
module mac_accum_chk #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           cmd_valid,
  input logic [1:0]     cmd_op,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [IW-1:0]  imm,
  input logic [W-1:0]   rd_data,
  input logic [2*W-1:0] acc_out
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (acc_out == '0 && rd_data == '0));

  // R8
  idle_acc_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(acc_out));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_op == 2'd3) |=> $stable(rd_data));

  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd3) |=> (acc_out == '0 && rd_data == $past(acc_out[W-1:0])));

  // R2
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op[1] == 1'b0 && op_a == '0) |=> $stable(acc_out));

  // R4
  zero_imm_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd2 && imm == '0) |=> $stable(acc_out));
endmodule

bind mac_accum mac_accum_chk #(.W(W), .IW(IW)) u_chk (.*);

// File: tb/tb_mac_accum.sv
module tb_mac_accum;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [31:0] op_a, op_b;
  logic [15:0] imm;
  logic [31:0] rd_data;
  logic [63:0] acc_out;

  logic [63:0] m_acc;
  logic [31:0] m_rd;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mac_accum dut (.clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
                 .op_a(op_a), .op_b(op_b), .imm(imm), .rd_data(rd_data), .acc_out(acc_out));

  function automatic logic [63:0] sprod(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] full;
    full = {32'd0, a} * {32'd0, b};
    return {{32{full[31]}}, full[31:0]};
  endfunction

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s acc actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s rd actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic v, input logic [1:0] op,
                      input logic [31:0] a, input logic [31:0] b, input logic [15:0] im);
    cmd_valid = v; cmd_op = op; op_a = a; op_b = b; imm = im;
    if (v) begin
      case (op)
        2'd0: m_acc = m_acc + sprod(a, b);
        2'd1: m_acc = m_acc - sprod(a, b);
        2'd2: m_acc = m_acc + sprod(a, {{16{im[15]}}, im});
        default: begin m_rd = m_acc[31:0]; m_acc = '0; end
      endcase
    end
    @(negedge clk);
    chk64(req, acc_out, m_acc);
    chk32(req, rd_data, m_rd);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; op_a = '0; op_b = '0; imm = '0;
    m_acc = '0; m_rd = '0;
    @(negedge clk); @(negedge clk);
    chk64("R1", acc_out, 64'd0);
    chk32("R1", rd_data, 32'd0);
    rst = 1'b0;

    step("R2", 1, 2'd0, 32'd3, 32'd4, 16'h0);
    step("R2", 1, 2'd0, 32'hFFFFFFFF, 32'd5, 16'h0);
    step("R3", 1, 2'd1, 32'd7, 32'hFFFFFFFE, 16'h0);
    step("R4", 1, 2'd2, 32'd9, 32'h12345678, 16'hFFFF);
    step("R4", 1, 2'd2, 32'd2, 32'hDEADBEEF, 16'h7FFF);
    step("R6", 1, 2'd3, 32'd0, 32'd0, 16'h0);
    step("R9", 1, 2'd0, 32'h00010000, 32'h00010000, 16'h0);
    chk64("R9", acc_out, 64'd0);
    step("R9", 1, 2'd0, 32'h00008000, 32'h00010000, 16'h0);
    chk64("R9", acc_out, 64'hFFFFFFFF80000000);
    step("R5", 1, 2'd3, 32'd0, 32'd0, 16'h0);
    chk32("R5", rd_data, 32'h80000000);
    step("R7", 1, 2'd1, 32'd1, 32'd1, 16'h0);
    chk64("R7", acc_out, 64'hFFFFFFFFFFFFFFFF);
    step("R7", 1, 2'd0, 32'd1, 32'd1, 16'h0);
    chk64("R7", acc_out, 64'd0);
    step("R2", 1, 2'd0, 32'h1234, 32'h10, 16'h0);
    step("R8", 0, 2'd3, 32'h55, 32'h66, 16'h77);
    step("R8", 0, 2'd0, 32'hFFFF, 32'hFFFF, 16'h1);
    step("R5", 1, 2'd2, 32'd1, 32'd1, 16'h1);
    step("R6", 1, 2'd3, 32'd0, 32'd0, 16'h0);
    chk32("R6", rd_data, 32'h00012341);

    for (int i = 0; i < 3000; i++) begin
      logic v;
      logic [1:0] op;
      v  = ($urandom % 5) != 0;
      op = 2'($urandom % 4);
      if (op == 2'd3 && ($urandom % 2) == 0) op = 2'($urandom % 3);
      step(v ? (op == 2'd3 ? "R5" : (op == 2'd1 ? "R3" : (op == 2'd2 ? "R4" : "R2"))) : "R8",
           v, op, $urandom, $urandom, 16'($urandom));
    end

    rst = 1'b1;
    @(negedge clk);
    m_acc = '0; m_rd = '0;
    chk64("R1", acc_out, 64'd0);
    chk32("R1", rd_data, 32'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule